// File: doc/BRIEF.md
# Last-Number Redial Digit Store

This block keeps the codes of the number most recently dialed so that the number can be dialed again. Each code is 5 bits wide and is written into a 32-word memory. The first 23 words of that memory hold the number. Codes are read back one at a time on request, in the order they were written, and are passed on to the line-dialing logic. Three counters follow the memory. The write count (P1) is the next location to fill. The read count (M1) is the next location to send. The capacity count (P2) is the number of codes that can still be trusted for redial. The difference P1 minus M1 is given out as the number of codes still pending.

Redial is allowed only while the capacity is non-zero. Three events clear the capacity for good, and only a reset brings it back: the RAM supply flag drops, a 24th code wraps storage back to location 0, or a manually dialed code differs from the stored code at the same position. A stored pause code starts a timed pause when it is read out, and reads are held off while the pause runs. A pause code written while a pause is running is not stored, and it ends the pause at once. The flash logic can send the read count back to the start without touching the stored codes.

Code values: digits 0 to 9 are 0 to 9, star is 10, hash is 11, pause is 12, and A to D are 13 to 16. Values 17 to 31 are not codes.

There are two state machines. The capacity machine has the states CAP_TRACK and CAP_LOST. It moves from CAP_TRACK to CAP_LOST on a supply drop, an overflow or a manual mismatch, and it never leaves CAP_LOST. The playback machine has the states PLAY_IDLE and PLAY_PAUSE. It moves from PLAY_IDLE to PLAY_PAUSE when a read sends out a pause code. It moves from PLAY_PAUSE back to PLAY_IDLE when the timer reaches its last cycle or when a pause code is written.

Top module: `redial_store`

## Requirements
- R1: After reset, pending, capacity, redial_ok, pause_busy, rd_valid and rd_empty are all 0.
- R2: A write with wr_valid and a code from 0 to 16 is stored at the write count, and pending rises by one at the next edge. A code from 17 to 31 is ignored, and pending and capacity stay unchanged.
- R3: A read request while pending is non-zero and no pause is running gives rd_valid high for one cycle in the cycle after the request. rd_code then carries the oldest code not yet sent, and pending falls by one.
- R4: A read request while pending is 0 and no pause is running gives rd_empty high for one cycle in the cycle after the request. rd_valid stays low and pending stays unchanged.
- R5: The 24th stored code is written to location 0. The write count becomes 1 and the read count becomes 0, so pending is 1 and the next read returns that code. Capacity drops to 0 and stays 0.
- R6: redial_start sends the read count back to 0 (pending becomes the write count) only while capacity is non-zero. When capacity is 0 it has no effect.
- R7: flash_rewind sends the read count back to 0 and the manual-compare position back to 0 whatever the capacity is. The stored codes are kept.
- R8: If supply_ok is low in any cycle, capacity is 0 from the next edge on. Writes and reads still work.
- R9: A valid manual code at compare position k, where k is below the capacity, is checked against stored location k. A match keeps the capacity and a mismatch clears it for good. Each valid manual code moves the position up by one.
- R10: A read that sends out code 12 makes pause_busy high for exactly PAUSE_CYC cycles, starting in the same cycle as rd_valid. Read requests in those cycles produce neither rd_valid nor rd_empty and leave pending unchanged.
- R11: A write of code 12 while pause_busy is high is not stored, so pending is unchanged. pause_busy is low after the next edge.
- R12: redial_ok is high exactly when capacity is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Code write strobe |
| wr_code | input | 5 | Code to store |
| rd_req | input | 1 | Request the next stored code |
| rd_valid | output | 1 | rd_code is valid this cycle |
| rd_code | output | 5 | Code read back |
| rd_empty | output | 1 | The last request found nothing pending |
| redial_start | input | 1 | Send the read count back to 0 for a redial |
| manual_valid | input | 1 | A manually dialed code is present |
| manual_code | input | 5 | Manually dialed code to compare |
| supply_ok | input | 1 | RAM supply is above the retention level |
| flash_rewind | input | 1 | Read-count reset from the flash logic |
| pause_busy | output | 1 | A pause is running |
| redial_ok | output | 1 | Redial is allowed |
| pending | output | 5 | Codes stored but not yet read |
| capacity | output | 5 | Valid redial capacity |

## Verification
A wrong write count or read count shows on pending at the very next edge, and on rd_code at the following read. A capacity machine that fails to latch CAP_LOST shows as capacity and redial_ok going non-zero after a supply drop, an overflow or a mismatch. Playback state errors show as a pause_busy window of the wrong length, or as rd_valid appearing while a pause should be holding reads off. A bench model running in lockstep compares every output in every cycle, so a fault becomes visible within one or two cycles of the stimulus that exposes it.

// File: rtl/rds_pkg.sv
package rds_pkg;
    typedef logic [4:0] code_t;

    localparam code_t CODE_PAUSE = 5'd12;
    localparam code_t CODE_MAX   = 5'd16;

    typedef enum logic {
        CAP_TRACK = 1'b0,
        CAP_LOST  = 1'b1
    } cap_state_t;

    typedef enum logic {
        PLAY_IDLE  = 1'b0,
        PLAY_PAUSE = 1'b1
    } play_state_t;
endpackage

// File: rtl/rds_mem.sv
module rds_mem #(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  rds_pkg::code_t    wdata,
    input  logic [AW-1:0]     raddr_a,
    output rds_pkg::code_t    rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output rds_pkg::code_t    rdata_b
);
    rds_pkg::code_t words [DEPTH];

    // The memory has no reset; only written locations are ever read.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Two combinational read ports: one for playback, one for the manual compare.
    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/rds_ptrs.sv
module rds_ptrs
    import rds_pkg::*;
#(
    parameter int STORE = 23,
    parameter int AW    = 5,
    parameter int CW    = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic           rd_fire,
    input  logic           flash_rewind,
    input  logic           redial_start,
    input  logic           supply_ok,
    input  logic           manual_valid,
    input  code_t          manual_code,
    input  code_t          cmp_data,
    output logic [AW-1:0]  waddr,
    output logic [AW-1:0]  raddr,
    output logic [AW-1:0]  cmp_addr,
    output logic           has_pending,
    output logic [CW-1:0]  pending,
    output logic [CW-1:0]  capacity
);
    logic [CW-1:0] p1_q, m1_q, p2_q, cmp_q;
    cap_state_t    cap_q, cap_d;
    logic          ovf, mismatch, kill, man_ok;

    always_comb begin
        ovf      = take && (p1_q == CW'(STORE));
        man_ok   = manual_valid && (manual_code <= CODE_MAX);
        mismatch = man_ok && (cmp_q < p2_q) && (cmp_data != manual_code);
        kill     = !supply_ok || ovf || mismatch;
        waddr    = ovf ? '0 : AW'(p1_q);
        raddr    = AW'(m1_q);
        cmp_addr = AW'(cmp_q);
    end

    // Write, read and compare positions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_q  <= '0;
            m1_q  <= '0;
            cmp_q <= '0;
        end else begin
            if (take) begin
                p1_q <= ovf ? CW'(1) : p1_q + CW'(1);
            end
            if (ovf || flash_rewind) begin
                m1_q <= '0;
            end else if (redial_start && (p2_q != '0)) begin
                m1_q <= '0;
            end else if (rd_fire) begin
                m1_q <= m1_q + CW'(1);
            end
            if (flash_rewind) begin
                cmp_q <= '0;
            end else if (man_ok && (cmp_q < CW'(STORE))) begin
                cmp_q <= cmp_q + CW'(1);
            end
        end
    end

    // Capacity machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= CAP_TRACK;
        end else begin
            cap_q <= cap_d;
        end
    end

    // Capacity machine: next state
    always_comb begin
        cap_d = cap_q;
        unique case (cap_q)
            CAP_TRACK: if (kill) cap_d = CAP_LOST;
            CAP_LOST:  cap_d = CAP_LOST;
            default:   cap_d = CAP_LOST;
        endcase
    end

    // Capacity machine: capacity count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p2_q <= '0;
        end else begin
            unique case (cap_q)
                CAP_TRACK: begin
                    if (kill) begin
                        p2_q <= '0;
                    end else if (take) begin
                        p2_q <= p2_q + CW'(1);
                    end
                end
                default: p2_q <= '0;
            endcase
        end
    end

    assign has_pending = (p1_q != m1_q);
    assign pending     = p1_q - m1_q;
    assign capacity    = p2_q;
endmodule

// File: rtl/rds_play.sv
module rds_play
    import rds_pkg::*;
#(
    parameter int PAUSE_CYC = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_req,
    input  logic   has_pending,
    input  code_t  rdata,
    input  logic   abort,
    output logic   rd_fire,
    output logic   rd_valid,
    output code_t  rd_code,
    output logic   rd_empty,
    output logic   pause_busy
);
    localparam int TW = $clog2(PAUSE_CYC + 1);

    play_state_t   state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          idle, empty_hit;

    always_comb begin
        idle      = (state_q == PLAY_IDLE);
        rd_fire   = rd_req && idle && has_pending;
        empty_hit = rd_req && idle && !has_pending;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PLAY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PLAY_IDLE: begin
                if (rd_fire && (rdata == CODE_PAUSE)) begin
                    state_d = PLAY_PAUSE;
                    cnt_d   = TW'(PAUSE_CYC);
                end
            end
            PLAY_PAUSE: begin
                if (abort || (cnt_q <= TW'(1))) begin
                    state_d = PLAY_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            default: begin
                state_d = PLAY_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_empty <= 1'b0;
            rd_code  <= '0;
        end else begin
            rd_valid <= rd_fire;
            rd_empty <= empty_hit;
            if (rd_fire) begin
                rd_code <= rdata;
            end
        end
    end

    assign pause_busy = (state_q == PLAY_PAUSE);
endmodule

// File: rtl/redial_store.sv
module redial_store
    import rds_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int STORE     = 23,
    parameter int PAUSE_CYC = 16,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(STORE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [4:0]    wr_code,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [4:0]    rd_code,
    output logic          rd_empty,
    input  logic          redial_start,
    input  logic          manual_valid,
    input  logic [4:0]    manual_code,
    input  logic          supply_ok,
    input  logic          flash_rewind,
    output logic          pause_busy,
    output logic          redial_ok,
    output logic [CW-1:0] pending,
    output logic [CW-1:0] capacity
);
    logic [AW-1:0] waddr, raddr, cmp_addr;
    code_t         rdata, cmp_data;
    logic          take, abort, rd_fire, has_pending, busy;

    always_comb begin
        abort = wr_valid && (wr_code == CODE_PAUSE) && busy;
        take  = wr_valid && (wr_code <= CODE_MAX) && !abort;
    end

    rds_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .we      (take),
        .waddr   (waddr),
        .wdata   (wr_code),
        .raddr_a (raddr),
        .rdata_a (rdata),
        .raddr_b (cmp_addr),
        .rdata_b (cmp_data)
    );

    rds_ptrs #(.STORE(STORE), .AW(AW), .CW(CW)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .rd_fire      (rd_fire),
        .flash_rewind (flash_rewind),
        .redial_start (redial_start),
        .supply_ok    (supply_ok),
        .manual_valid (manual_valid),
        .manual_code  (manual_code),
        .cmp_data     (cmp_data),
        .waddr        (waddr),
        .raddr        (raddr),
        .cmp_addr     (cmp_addr),
        .has_pending  (has_pending),
        .pending      (pending),
        .capacity     (capacity)
    );

    rds_play #(.PAUSE_CYC(PAUSE_CYC)) u_play (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .has_pending (has_pending),
        .rdata       (rdata),
        .abort       (abort),
        .rd_fire     (rd_fire),
        .rd_valid    (rd_valid),
        .rd_code     (rd_code),
        .rd_empty    (rd_empty),
        .pause_busy  (busy)
    );

    assign pause_busy = busy;
    assign redial_ok  = (capacity != '0);
endmodule

// File: rtl/rds_checker.sv
module rds_checker #(
    parameter int STORE = 23,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_valid,
    input logic [4:0]    rd_code,
    input logic          rd_empty,
    input logic          supply_ok,
    input logic          pause_busy,
    input logic [CW-1:0] pending,
    input logic [CW-1:0] capacity
);
    a_r2_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= CW'(STORE));

    a_r5_capacity_bound: assert property (@(posedge clk) disable iff (!rst_n)
        capacity <= CW'(STORE));

    a_r5_capacity_step: assert property (@(posedge clk) disable iff (!rst_n)
        (capacity != '0) |=> (capacity == '0) || (capacity == $past(capacity))
                             || (capacity == $past(capacity) + CW'(1)));

    a_r8_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (capacity == '0));

    a_r4_valid_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_empty));

    a_r4_empty_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (pending == '0) && !pause_busy) |=> (rd_empty && !rd_valid));

    a_r10_busy_holds_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && pause_busy) |=> (!rd_valid && !rd_empty));

    a_r10_pause_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_code == 5'd12)) |-> pause_busy);
endmodule

bind redial_store rds_checker #(.STORE(STORE), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_code    (rd_code),
    .rd_empty   (rd_empty),
    .supply_ok  (supply_ok),
    .pause_busy (pause_busy),
    .pending    (pending),
    .capacity   (capacity)
);

// File: tb/redial_store_tb.sv
`timescale 1ns/1ps
module redial_store_tb;
    localparam int STORE = 23;
    localparam int PAUSE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, rd_req = 1'b0, redial_start = 1'b0;
    logic       manual_valid = 1'b0, supply_ok = 1'b1, flash_rewind = 1'b0;
    logic [4:0] wr_code = '0, manual_code = '0;
    logic       rd_valid, rd_empty, pause_busy, redial_ok;
    logic [4:0] rd_code, pending, capacity;

    int checks = 0;
    int errors = 0;

    // bench model state
    int mmem [STORE];
    int mp1, mm1, mp2, mcidx, mcnt;
    bit mlost, e_valid, e_empty;
    int e_code;

    always #10 clk = ~clk;

    redial_store #(.PAUSE_CYC(PAUSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_code(rd_code), .rd_empty(rd_empty),
        .redial_start(redial_start), .manual_valid(manual_valid),
        .manual_code(manual_code), .supply_ok(supply_ok), .flash_rewind(flash_rewind),
        .pause_busy(pause_busy), .redial_ok(redial_ok), .pending(pending),
        .capacity(capacity)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_pending();
        return mp1 - mm1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < STORE; i++) mmem[i] = 0;
        mp1 = 0; mm1 = 0; mp2 = 0; mcidx = 0; mcnt = 0;
        mlost = 0; e_valid = 0; e_empty = 0; e_code = 0;
    endtask

    task automatic model_step(input bit wv, input int wc, input bit rq, input bit rs,
                              input bit mv, input int mc, input bit sup, input bit fl);
        bit busy, abort, take, ovf, mism, fire;
        int rdat;
        busy  = (mcnt > 0);
        abort = wv && (wc == 12) && busy;
        take  = wv && (wc <= 16) && !abort;
        ovf   = take && (mp1 == STORE);
        mism  = mv && (mc <= 16) && (mcidx < mp2) && (mmem[mcidx] != mc);
        fire  = rq && !busy && (mm1 != mp1);
        rdat  = fire ? mmem[mm1] : 0;
        e_valid = fire;
        e_empty = rq && !busy && (mm1 == mp1);
        if (fire) e_code = rdat;
        if (busy) begin
            if (abort) mcnt = 0; else mcnt = mcnt - 1;
        end else if (fire && rdat == 12) begin
            mcnt = PAUSE;
        end
        if (!mlost) begin
            if (!sup || ovf || mism) begin
                mlost = 1; mp2 = 0;
            end else if (take) begin
                mp2 = mp2 + 1;
            end
        end
        if (fl || ovf) mm1 = 0;
        else if (rs && mp2_old_nz) mm1 = 0;
        else if (fire) mm1 = mm1 + 1;
        if (fl) mcidx = 0;
        else if (mv && mc <= 16 && mcidx < STORE) mcidx = mcidx + 1;
        if (take) begin
            mmem[ovf ? 0 : mp1] = wc;
            mp1 = ovf ? 1 : mp1 + 1;
        end
    endtask

    bit mp2_old_nz;

    task automatic step(input bit wv = 0, input int wc = 0, input bit rq = 0,
                        input bit rs = 0, input bit mv = 0, input int mc = 0,
                        input bit sup = 1, input bit fl = 0);
        wr_valid = wv; wr_code = 5'(wc); rd_req = rq; redial_start = rs;
        manual_valid = mv; manual_code = 5'(mc); supply_ok = sup; flash_rewind = fl;
        @(posedge clk);
        mp2_old_nz = (mp2 != 0);
        model_step(wv, wc, rq, rs, mv, mc, sup, fl);
        #1;
        chk("R2 pending", int'(pending), next_pending());
        chk("R5 capacity", int'(capacity), mp2);
        chk("R12 redial_ok", int'(redial_ok), int'(mp2 != 0));
        chk("R3 rd_valid", int'(rd_valid), int'(e_valid));
        chk("R4 rd_empty", int'(rd_empty), int'(e_empty));
        chk("R10 pause_busy", int'(pause_busy), int'(mcnt > 0));
        if (e_valid) chk("R3 rd_code", int'(rd_code), e_code);
    endtask

    task automatic do_reset();
        wr_valid = 0; rd_req = 0; redial_start = 0; manual_valid = 0;
        supply_ok = 1; flash_rewind = 0;
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        model_reset();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        chk("R1 pending", int'(pending), 0);
        chk("R1 capacity", int'(capacity), 0);
        chk("R1 redial_ok", int'(redial_ok), 0);
        chk("R1 pause_busy", int'(pause_busy), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_empty", int'(rd_empty), 0);

        // R2 writes and an ignored code
        step(.wv(1), .wc(3)); step(.wv(1), .wc(7)); step(.wv(1), .wc(10));
        chk("R2 three stored", int'(pending), 3);
        step(.wv(1), .wc(20));
        chk("R2 code 20 ignored", int'(pending), 3);
        chk("R2 code 20 capacity", int'(capacity), 3);
        // R3 ordered read-back
        step(.rq(1)); chk("R3 first code", int'(rd_code), 3);
        step(.rq(1)); chk("R3 second code", int'(rd_code), 7);
        step(.rq(1)); chk("R3 third code", int'(rd_code), 10);
        // R4 empty read
        step(.rq(1));
        chk("R4 empty flag", int'(rd_empty), 1);
        chk("R4 pending kept", int'(pending), 0);
        // R6 redial rewinds
        step(.rs(1));
        chk("R6 rewind", int'(pending), 3);
        chk("R12 allowed", int'(redial_ok), 1);
        // R7 flash rewinds
        step(.rq(1));
        step(.fl(1));
        chk("R7 flash rewind", int'(pending), 3);
        // R9 manual compare
        step(.mv(1), .mc(3));
        chk("R9 match keeps", int'(capacity), 3);
        step(.mv(1), .mc(5));
        chk("R9 mismatch clears", int'(capacity), 0);
        chk("R12 refused", int'(redial_ok), 0);
        // R6 refused redial has no effect
        step(.rq(1));
        step(.rs(1));
        chk("R6 no rewind when empty", int'(pending), 2);

        // R10 pause playback
        do_reset();
        step(.wv(1), .wc(12)); step(.wv(1), .wc(4));
        step(.rq(1));
        chk("R10 pause code out", int'(rd_code), 12);
        chk("R10 busy starts", int'(pause_busy), 1);
        begin
            int n = 0;
            while (pause_busy && n < 20) begin
                n++;
                step(.rq(1));
                chk("R10 read held", int'(rd_valid), 0);
            end
            chk("R10 pause length", n, PAUSE);
        end
        step(.rq(1));
        chk("R10 read after pause", int'(rd_code), 4);

        // R11 pause abort
        do_reset();
        step(.wv(1), .wc(12));
        step(.rq(1));
        step(.wv(1), .wc(12));
        chk("R11 not stored", int'(pending), 0);
        chk("R11 pause ended", int'(pause_busy), 0);

        // R5 overflow
        do_reset();
        for (int i = 0; i < STORE; i++) step(.wv(1), .wc(i % 10));
        chk("R5 full capacity", int'(capacity), STORE);
        chk("R5 full pending", int'(pending), STORE);
        step(.wv(1), .wc(9));
        chk("R5 overflow capacity", int'(capacity), 0);
        chk("R5 overflow pending", int'(pending), 1);
        step(.rq(1));
        chk("R5 wrapped code", int'(rd_code), 9);
        step(.wv(1), .wc(2));
        chk("R5 stays lost", int'(capacity), 0);

        // R8 supply drop
        do_reset();
        step(.wv(1), .wc(1)); step(.wv(1), .wc(2));
        step(.sup(0));
        chk("R8 capacity cleared", int'(capacity), 0);
        step(.wv(1), .wc(3));
        chk("R8 stays cleared", int'(capacity), 0);
        chk("R8 writes continue", int'(pending), 3);

        // constrained random, three mixes
        for (int blk = 0; blk < 3; blk++) begin
            do_reset();
            for (int c = 0; c < 400; c++) begin
                int r = int'($urandom % 100);
                int wlim = (blk == 0) ? 45 : 30;
                if (r < wlim) begin
                    int code = (($urandom % 4) == 0) ? 12 : int'($urandom % 19);
                    step(.wv(1), .wc(code));
                end else if (r < wlim + 35) begin
                    step(.rq(1));
                end else if (r < wlim + 40) begin
                    step(.fl(1));
                end else if (r < wlim + 45) begin
                    step(.rs(1));
                end else if (r < wlim + 53) begin
                    int mc = (mcidx < mp2 && ($urandom % 5) != 0) ? mmem[mcidx]
                                                                    : int'($urandom % 17);
                    step(.mv(1), .mc(mc));
                end else if (r < wlim + 54 && blk == 2) begin
                    step(.sup(0));
                end else begin
                    step();
                end
            end
        end
        summary();
    end
endmodule